// File: doc/BRIEF.md
# Programmable Probe Trigger Unit

This unit watches four probe inputs (three single-bit probes and one wide probe, 4 bits by default). It raises a trigger pulse when any enabled probe condition holds. Each probe has its own pair of 16-bit registers. The operation register selects a comparison, and the argument register holds the value the probe is compared against. The comparisons cover equality, inequality, ordering, and rising, falling or changing values relative to the probe's sample from the previous cycle.

The registers are reached over a chained request bus. Each request carries an address, write data, read data, a direction bit and a one-cycle valid strobe. Every request leaves on the outgoing bus one cycle later, whether or not it hit this unit. Requests whose address falls outside the unit's window pass through untouched. Reads inside the window replace the read data field with the register contents. The bus has no ready signal, so a downstream stage can apply no back-pressure: one request may enter every cycle, and the requester treats the outgoing valid as its completion. Sample storage and capture sequencing belong to other blocks on the chain.

Top module: `trig_unit`

## Requirements
- R1: Synchronous active-high reset clears all operation and argument registers, the outgoing valid and the trigger output. A read of any register after reset returns 0.
- R2: When a request's address is outside the window, the request appears on the outgoing bus exactly one cycle later with address, write data, read data, direction and valid unchanged.
- R3: A write inside the window (direction bit 1 = write) updates the addressed register. An argument register reads back all 16 bits unchanged. An operation register keeps only bits 3:0 and reads back with bits 15:4 zero.
- R4: A read inside the window (direction bit 0) appears one cycle later on the outgoing bus with the register contents as read data and all other fields unchanged.
- R5: The window starts at parameter BASE_ADDR (default 2) and holds one pair of registers per probe in the order a, b, c, d. Probe k has its operation register at BASE_ADDR+2k and its argument register at BASE_ADDR+2k+1, so with the defaults the wide probe uses addresses 8 and 9.
- R6: Operation code 8 fires when the probe equals the argument, and code 9 fires when they differ.
- R7: Operation codes 4, 5, 6 and 7 fire when the probe is greater or equal, less or equal, greater than, or less than the argument. The probe is zero-extended to 16 bits and compared without sign against the full 16-bit argument. For example, code 6 with argument 3 fires for a wide-probe value of 4.
- R8: Operation codes 1, 2 and 3 compare the probe with its own sample from the previous cycle. Code 1 fires when the value went up, code 2 when it went down, and code 3 when it changed. The previous sample is 0 right after reset.
- R9: Operation code 0 and codes 10 to 15 disable a probe. The trigger is the OR of all probe conditions, and it is low whenever every probe is disabled.
- R10: The trigger output is registered. It reflects the probe values and register contents of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_a | input | 1 | Probe 0 |
| probe_b | input | 1 | Probe 1 |
| probe_c | input | 1 | Probe 2 |
| probe_d | input | WIDE_W | Probe 3, wide |
| bus_addr_i | input | 16 | Incoming request address |
| bus_wdata_i | input | 16 | Incoming write data |
| bus_rdata_i | input | 16 | Incoming read data from upstream |
| bus_we_i | input | 1 | Direction, 1 = write, 0 = read |
| bus_valid_i | input | 1 | One-cycle request strobe |
| bus_addr_o | output | 16 | Forwarded address |
| bus_wdata_o | output | 16 | Forwarded write data |
| bus_rdata_o | output | 16 | Forwarded or replaced read data |
| bus_we_o | output | 1 | Forwarded direction |
| bus_valid_o | output | 1 | Forwarded strobe |
| trig_o | output | 1 | Registered trigger |

## Verification
The assertions assume the following about the inputs:
- Probes and bus fields are stable around the rising edge.
- The valid strobe is a plain level sampled each cycle.
- Nothing depends on input values seen during reset.

The bench changes every input only on the falling clock edge, holds reset for several cycles before releasing it, and mixes random requests with random addresses across and beyond the window. Random operation codes, including the unused ones, and random probe values are mixed with directed writes and reads at the window edges and directed comparisons at their thresholds.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int BUS_W      = 16;
  localparam int OP_W       = 4;
  localparam int NUM_PROBES = 4;

  localparam logic [OP_W-1:0] OP_OFF  = 4'd0;
  localparam logic [OP_W-1:0] OP_RISE = 4'd1;
  localparam logic [OP_W-1:0] OP_FALL = 4'd2;
  localparam logic [OP_W-1:0] OP_CHG  = 4'd3;
  localparam logic [OP_W-1:0] OP_GE   = 4'd4;
  localparam logic [OP_W-1:0] OP_LE   = 4'd5;
  localparam logic [OP_W-1:0] OP_GT   = 4'd6;
  localparam logic [OP_W-1:0] OP_LT   = 4'd7;
  localparam logic [OP_W-1:0] OP_EQ   = 4'd8;
  localparam logic [OP_W-1:0] OP_NE   = 4'd9;

  typedef struct packed {
    logic [BUS_W-1:0] addr;
    logic [BUS_W-1:0] wdata;
    logic [BUS_W-1:0] rdata;
    logic             we;
    logic             valid;
  } bus_req_t;
endpackage

// File: rtl/trig_probe_cond.sv
module trig_probe_cond
  import trig_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     probe,
  input  logic [OP_W-1:0]  op,
  input  logic [BUS_W-1:0] arg,
  output logic             cond
);
  logic [W-1:0]     prev_q;
  logic [BUS_W-1:0] cur_x;
  logic [BUS_W-1:0] prev_x;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= probe;
  end

  assign cur_x  = BUS_W'(probe);
  assign prev_x = BUS_W'(prev_q);

  always_comb begin
    case (op)
      OP_RISE: cond = cur_x > prev_x;
      OP_FALL: cond = cur_x < prev_x;
      OP_CHG:  cond = cur_x != prev_x;
      OP_GE:   cond = cur_x >= arg;
      OP_LE:   cond = cur_x <= arg;
      OP_GT:   cond = cur_x > arg;
      OP_LT:   cond = cur_x < arg;
      OP_EQ:   cond = cur_x == arg;
      OP_NE:   cond = cur_x != arg;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_regbank.sv
module trig_regbank
  import trig_pkg::*;
#(
  parameter int BASE_ADDR = 2,
  parameter int N         = NUM_PROBES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bus_req_t                  req_i,
  output bus_req_t                  req_o,
  output logic [N-1:0][OP_W-1:0]    op_q,
  output logic [N-1:0][BUS_W-1:0]   arg_q
);
  localparam logic [BUS_W-1:0] LO = BASE_ADDR[BUS_W-1:0];
  localparam logic [BUS_W-1:0] HI = LO + BUS_W'(2 * N);

  logic             hit;
  logic [BUS_W-1:0] offs;
  logic [N-1:0]     wr_op;
  logic [N-1:0]     wr_arg;
  logic [BUS_W-1:0] rd_val;
  logic             live;

  assign hit  = (req_i.addr >= LO) && (req_i.addr < HI);
  assign offs = req_i.addr - LO;

  for (genvar k = 0; k < N; k++) begin : g_regs
    assign wr_op[k]  = req_i.valid && req_i.we && hit && (offs == BUS_W'(2 * k));
    assign wr_arg[k] = req_i.valid && req_i.we && hit && (offs == BUS_W'(2 * k + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        op_q[k]  <= '0;
        arg_q[k] <= '0;
      end else begin
        if (wr_op[k])  op_q[k]  <= req_i.wdata[OP_W-1:0];
        if (wr_arg[k]) arg_q[k] <= req_i.wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N; k++) begin
      if (offs == BUS_W'(2 * k))     rd_val = BUS_W'(op_q[k]);
      if (offs == BUS_W'(2 * k + 1)) rd_val = arg_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= '0;
      live  <= 1'b0;
    end else begin
      live        <= 1'b1;
      req_o.addr  <= req_i.addr;
      req_o.wdata <= req_i.wdata;
      req_o.we    <= req_i.we;
      req_o.valid <= req_i.valid;
      req_o.rdata <= (req_i.valid && !req_i.we && hit) ? rd_val : req_i.rdata;
    end
  end

  AST_VALID_FWD: assert property (@(posedge clk) disable iff (rst)
    live |-> req_o.valid == $past(req_i.valid)); // R2
  AST_ADDR_FWD: assert property (@(posedge clk) disable iff (rst)
    live && $past(req_i.valid) |-> req_o.addr == $past(req_i.addr)); // R2
  AST_MISS_RDATA: assert property (@(posedge clk) disable iff (rst)
    live && $past(req_i.valid && !hit) |-> req_o.rdata == $past(req_i.rdata)); // R2
  AST_ARG_HOLD: assert property (@(posedge clk) disable iff (rst)
    live && !$past(req_i.valid && req_i.we) |-> $stable(arg_q)); // R3
  AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    live && !$past(req_i.valid && req_i.we) |-> $stable(op_q)); // R3
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int BASE_ADDR = 2,
  parameter int WIDE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              probe_a,
  input  logic              probe_b,
  input  logic              probe_c,
  input  logic [WIDE_W-1:0] probe_d,
  input  logic [15:0]       bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_we_i,
  input  logic              bus_valid_i,
  output logic [15:0]       bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic [15:0]       bus_rdata_o,
  output logic              bus_we_o,
  output logic              bus_valid_o,
  output logic              trig_o
);
  localparam int N = NUM_PROBES;

  bus_req_t                    req_in;
  bus_req_t                    req_out;
  logic [N-1:0][OP_W-1:0]      op_q;
  logic [N-1:0][BUS_W-1:0]     arg_q;
  logic [N-1:0][WIDE_W-1:0]    probe_pk;
  logic [N-1:0]                cond;
  logic                        all_off;
  logic                        live;

  assign req_in = '{addr: bus_addr_i, wdata: bus_wdata_i, rdata: bus_rdata_i,
                    we: bus_we_i, valid: bus_valid_i};

  trig_regbank #(.BASE_ADDR(BASE_ADDR), .N(N)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_in),
    .req_o (req_out),
    .op_q  (op_q),
    .arg_q (arg_q)
  );

  assign bus_addr_o  = req_out.addr;
  assign bus_wdata_o = req_out.wdata;
  assign bus_rdata_o = req_out.rdata;
  assign bus_we_o    = req_out.we;
  assign bus_valid_o = req_out.valid;

  assign probe_pk[0] = WIDE_W'(probe_a);
  assign probe_pk[1] = WIDE_W'(probe_b);
  assign probe_pk[2] = WIDE_W'(probe_c);
  assign probe_pk[3] = probe_d;

  for (genvar k = 0; k < N; k++) begin : g_cond
    trig_probe_cond #(.W(WIDE_W)) u_cond (
      .clk   (clk),
      .rst   (rst),
      .probe (probe_pk[k]),
      .op    (op_q[k]),
      .arg   (arg_q[k]),
      .cond  (cond[k])
    );
  end

  always_comb begin
    all_off = 1'b1;
    for (int k = 0; k < N; k++)
      if (op_q[k] != OP_OFF && op_q[k] <= OP_NE) all_off = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o <= 1'b0;
      live   <= 1'b0;
    end else begin
      trig_o <= |cond;
      live   <= 1'b1;
    end
  end

  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    live && $past(all_off) |-> !trig_o); // R9
  AST_WIDE_EQ_FIRES: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_q[3] == OP_EQ && BUS_W'(probe_d) == arg_q[3]) |-> trig_o); // R6
  AST_WIDE_GT_FIRES: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_q[3] == OP_GT && BUS_W'(probe_d) > arg_q[3]) |-> trig_o); // R7
endmodule

// File: tb/trig_unit_tb.sv
`timescale 1ns/1ps
module trig_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        pa, pb, pc;
  logic [3:0]  pd;
  logic [15:0] a_i, wd_i, rd_i, a_o, wd_o, rd_o;
  logic        we_i, v_i, we_o, v_o, trig;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0]  op_m  [4];
  logic [15:0] arg_m [4];
  logic [15:0] prev_m[4];

  always #10 clk = ~clk;

  trig_unit #(.BASE_ADDR(2), .WIDE_W(4)) dut_i (
    .clk(clk), .rst(rst),
    .probe_a(pa), .probe_b(pb), .probe_c(pc), .probe_d(pd),
    .bus_addr_i(a_i), .bus_wdata_i(wd_i), .bus_rdata_i(rd_i),
    .bus_we_i(we_i), .bus_valid_i(v_i),
    .bus_addr_o(a_o), .bus_wdata_o(wd_o), .bus_rdata_o(rd_o),
    .bus_we_o(we_o), .bus_valid_o(v_o), .trig_o(trig)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cond_f(input logic [3:0] op, input logic [15:0] cur,
                                input logic [15:0] prv, input logic [15:0] arg);
    case (op)
      4'd1: return cur > prv;
      4'd2: return cur < prv;
      4'd3: return cur != prv;
      4'd4: return cur >= arg;
      4'd5: return cur <= arg;
      4'd6: return cur > arg;
      4'd7: return cur < arg;
      4'd8: return cur == arg;
      4'd9: return cur != arg;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit in_win(input logic [15:0] a);
    return a >= 16'd2 && a < 16'd10;
  endfunction

  function automatic logic [15:0] reg_val(input logic [15:0] a);
    int k = (int'(a) - 2) / 2;
    if (a[0] == 1'b0) return {12'd0, op_m[k]};
    return arg_m[k];
  endfunction

  // One cycle: drive at the falling edge, predict, advance, check at next falling edge.
  task automatic step(input logic [15:0] a, input logic [15:0] wd, input logic [15:0] rd,
                      input logic we, input logic v, input logic [3:0] probes_in,
                      input logic [3:0] wide, input string ttag);
    logic [15:0] cur[4];
    bit          exp_t;
    logic [15:0] exp_rd;
    string       btag;
    a_i = a; wd_i = wd; rd_i = rd; we_i = we; v_i = v;
    pa = probes_in[0]; pb = probes_in[1]; pc = probes_in[2]; pd = wide;
    cur[0] = 16'(probes_in[0]); cur[1] = 16'(probes_in[1]);
    cur[2] = 16'(probes_in[2]); cur[3] = 16'(wide);
    exp_t = 1'b0;
    for (int k = 0; k < 4; k++) exp_t |= cond_f(op_m[k], cur[k], prev_m[k], arg_m[k]);
    exp_rd = (v && !we && in_win(a)) ? reg_val(a) : rd;
    btag = !in_win(a) ? "R2" : (we ? "R3" : "R4");
    if (v && we && in_win(a)) begin
      int k = (int'(a) - 2) / 2;
      if (a[0] == 1'b0) op_m[k] = wd[3:0];
      else              arg_m[k] = wd;
    end
    for (int k = 0; k < 4; k++) prev_m[k] = cur[k];
    @(posedge clk);
    @(negedge clk);
    chk(trig === exp_t, ttag, "trig", 32'(trig), 32'(exp_t));
    chk(v_o === v, btag, "valid", 32'(v_o), 32'(v));
    if (v) begin
      chk(a_o === a && wd_o === wd && we_o === we, btag, "fields",
          {a_o, wd_o}, {a, wd});
      chk(rd_o === exp_rd, btag, "rdata", 32'(rd_o), 32'(exp_rd));
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input string t);
    step(a, d, 16'h0, 1'b1, 1'b1, 4'd0, 4'd0, t);
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string t);
    step(a, 16'h0, 16'h5A5A, 1'b0, 1'b1, 4'd0, 4'd0, t);
    chk(rd_o === exp, t, "readback", 32'(rd_o), 32'(exp));
  endtask

  task automatic idle(input logic [3:0] p, input logic [3:0] w, input string t);
    step(16'h0, 16'h0, 16'h0, 1'b0, 1'b0, p, w, t);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; pa = 0; pb = 0; pc = 0; pd = 0;
    a_i = 16'h3; wd_i = 16'hFFFF; rd_i = 0; we_i = 1; v_i = 1;
    for (int k = 0; k < 4; k++) begin op_m[k] = 0; arg_m[k] = 0; prev_m[k] = 0; end
    repeat (4) @(negedge clk);
    chk(v_o === 1'b0 && trig === 1'b0, "R1", "reset outputs", {v_o, trig}, 0);
    rst = 1'b0;
    // R1: all registers read as zero after reset
    for (int k = 2; k < 10; k++) rd(16'(k), 16'h0, "R1");
    // R2: outside the window on both sides
    step(16'h1, 16'h1234, 16'hCAFE, 1'b1, 1'b1, 4'd0, 4'd0, "R2");
    step(16'hA, 16'h4321, 16'hBEEF, 1'b0, 1'b1, 4'd0, 4'd0, "R2");
    rd(16'h0, 16'h5A5A, "R2");
    // R3: full argument readback, operation keeps low nibble
    wr(16'h9, 16'hBEEF, "R3"); rd(16'h9, 16'hBEEF, "R3");
    wr(16'h8, 16'hFFF8, "R3"); rd(16'h8, 16'h0008, "R3");
    wr(16'h8, 16'h0, "R3"); wr(16'h9, 16'h0, "R3");
    // R5 + R7: wide probe at 8/9, greater-than 3
    wr(16'h8, 16'd6, "R5"); wr(16'h9, 16'd3, "R5");
    idle(4'd0, 4'd3, "R7");
    idle(4'd0, 4'd4, "R7");
    chk(trig === 1'b1, "R7", "gt fires at 4", 32'(trig), 1);
    wr(16'h8, 16'd5, "R7"); idle(4'd0, 4'd3, "R7"); idle(4'd0, 4'd4, "R7");
    wr(16'h8, 16'd0, "R9");
    // R6: probe a equality, via 2/3
    wr(16'h2, 16'd8, "R6"); wr(16'h3, 16'd1, "R6");
    idle(4'b0001, 4'd0, "R6");
    chk(trig === 1'b1, "R6", "eq fires", 32'(trig), 1);
    idle(4'b0000, 4'd0, "R6");
    wr(16'h2, 16'd9, "R6"); idle(4'b0001, 4'd0, "R6"); idle(4'b0000, 4'd0, "R6");
    // R8: edges on probe c (6/7)
    wr(16'h2, 16'd0, "R8"); wr(16'h6, 16'd1, "R8");
    idle(4'b0000, 4'd0, "R8"); idle(4'b0100, 4'd0, "R8");
    chk(trig === 1'b1, "R8", "rise", 32'(trig), 1);
    idle(4'b0100, 4'd0, "R8");
    chk(trig === 1'b0, "R8", "no rise while high", 32'(trig), 0);
    wr(16'h6, 16'd2, "R8"); idle(4'b0000, 4'd0, "R8");
    wr(16'h6, 16'd3, "R8"); idle(4'b0100, 4'd0, "R8");
    // R9: unused code disables
    wr(16'h6, 16'd12, "R9"); idle(4'b0000, 4'd0, "R9"); idle(4'b0100, 4'd0, "R9");
    chk(trig === 1'b0, "R9", "code 12 silent", 32'(trig), 0);
    wr(16'h6, 16'd0, "R9");
    // R10: random mix, trigger latency and bus checked every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ad = 16'($urandom_range(0, 12));
      logic [15:0] dd = (ad[0] == 1'b0) ? 16'($urandom_range(0, 15)) : 16'($urandom_range(0, 16));
      if ($urandom_range(0, 7) == 0) dd = 16'($urandom);
      step(ad, dd, 16'($urandom), 1'($urandom), 1'($urandom_range(0, 2) == 0),
           4'($urandom), 4'($urandom), "R10");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule